// File: doc/BRIEF.md
# Odd/Even Split Bus-Invert Encoder

This block prepares data words for a parallel on-chip bus to reduce coupling energy between neighbouring wires. Each data word has two extra flag wires. For every accepted word the encoder builds four candidate bus words:

- plain data,
- data with the even-indexed bits flipped,
- data with the odd-indexed bits flipped,
- data with every bit flipped.

For each candidate it scores the coupling transitions on every adjacent wire pair, measured against the word the bus currently holds. It then registers the cheapest candidate onto the bus.

The two flag wires carry the chosen mode, so that a receiver can restore the data. A matching decoder sits inside the top module. It turns the driven bus back into plain data, so the round trip is visible at the ports every cycle.

A producer presents `in_data` with `in_valid` high for one cycle per word. One cycle later the encoded word appears on `bus_out` and `bus_valid` pulses. When `in_valid` is low the bus keeps its last value, so no wire switches. The held value also stays the reference for the next comparison.

The control is a two-state machine.
- States: `ST_IDLE` (no word driven in the last cycle) and `ST_SEND` (a word was driven in the last cycle).
- Transitions: `go_send` is taken from either state when `in_valid` is high. `go_idle` is taken from either state when `in_valid` is low.

Top module: `oebi_encoder`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first accepted word, `bus_out` is all zeros and `bus_valid` is 0.
- R2: Bus layout for DATA_W data bits and mode `{m1,m0}`:
  - `bus_out[0]` holds m1, the odd-flip flag.
  - `bus_out[DATA_W+1]` holds m0, the even-flip flag.
  - `bus_out[i+1]` holds `in_data[i] ^ (i even ? m0 : m1)`.
  - Mode values: 00 is plain, 01 flips the even-indexed bits, 10 flips the odd-indexed bits, 11 flips all bits.
- R3: The cost of one adjacent wire pair is |Δa − Δb|, where each Δ is new minus old and lies in {−1, 0, +1}.
  - A pair that charges or discharges against its neighbour costs 1.
  - A pair whose two wires swing in opposite directions costs 2.
  - A pair whose wires move together, or do not move, costs 0.
  - The candidate cost is the sum over all DATA_W+1 pairs, flag wires included.
- R4: The transmitted candidate has the lowest cost of the four, each cost taken against the current `bus_out`.
- R5: When several modes share the lowest cost, the one with the smallest numeric mode value is sent.
- R6: A word accepted at a rising edge (`in_valid` high) appears on `bus_out` at that edge. `bus_valid` is high for exactly the cycles that follow an accepting edge.
- R7: An edge with `in_valid` low leaves `bus_out` unchanged and drives `bus_valid` low. The next word is then scored against the held value.
- R8: Whenever `bus_valid` is high, `rt_data` (the decoder output) equals the data word that was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Word on `in_data` is accepted at this edge |
| in_data | input | DATA_W | Data word to encode |
| bus_out | output | DATA_W+2 | Encoded bus, flag wires at both ends |
| bus_valid | output | 1 | High for the cycle after an accepted word |
| rt_data | output | DATA_W | Data recovered from `bus_out` by the decoder |

## Verification
A wrong reference word, such as a register that moves on idle cycles or fails to clear at reset, does not show at once. It shows on the next accepted word, as a mode choice different from the one a model scoring against the true held value would make. A wrong pair weight or a wrong tie order shows the same way, on the first word whose candidates differ only in toggle pairs or tie.

Flag wires placed or decoded wrongly break `rt_data` in the same cycle that `bus_valid` rises. Stray switching during idle shows as a `bus_out` change in the cycle after the idle edge.

// File: rtl/oebi_pkg.sv
package oebi_pkg;

    // Transmission modes: bit 0 flips even-indexed data bits, bit 1 flips odd ones.
    typedef enum logic [1:0] {
        MODE_PLAIN = 2'b00,
        MODE_EVEN  = 2'b01,
        MODE_ODD   = 2'b10,
        MODE_ALL   = 2'b11
    } inv_mode_e;

    localparam int NUM_MODES = 4;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } enc_state_e;

endpackage

// File: rtl/oebi_candidates.sv
module oebi_candidates #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0]                            data_i,
    output logic [oebi_pkg::NUM_MODES-1:0][DATA_W+1:0]   cand_o
);
    localparam int BUS_W = DATA_W + 2;

    for (genvar m = 0; m < oebi_pkg::NUM_MODES; m++) begin : g_mode
        localparam logic [1:0] MV = 2'(m);
        // flag wires at both ends of the bus
        assign cand_o[m][0]       = MV[1];
        assign cand_o[m][BUS_W-1] = MV[0];
        for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            if ((i % 2) == 0) begin : g_even
                assign cand_o[m][i+1] = data_i[i] ^ MV[0];
            end else begin : g_odd
                assign cand_o[m][i+1] = data_i[i] ^ MV[1];
            end
        end
    end

endmodule

// File: rtl/oebi_pair_cost.sv
module oebi_pair_cost #(
    parameter int BUS_W  = 10,
    parameter int COST_W = 5
) (
    input  logic [BUS_W-1:0]  prev_i,
    input  logic [BUS_W-1:0]  next_i,
    output logic [COST_W-1:0] cost_o
);
    localparam int PAIRS = BUS_W - 1;

    logic [PAIRS-1:0][1:0] pair_w;

    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        logic rel_old, rel_new, lo_moved, toggle;
        assign rel_old  = prev_i[p] ^ prev_i[p+1];
        assign rel_new  = next_i[p] ^ next_i[p+1];
        assign lo_moved = prev_i[p] ^ next_i[p];
        // opposite swings: differing before and after, and a wire moved
        assign toggle   = rel_old & rel_new & lo_moved;
        always_comb begin
            if (rel_old != rel_new) begin
                pair_w[p] = 2'd1;
            end else if (toggle) begin
                pair_w[p] = 2'd2;
            end else begin
                pair_w[p] = 2'd0;
            end
        end
    end

    always_comb begin
        cost_o = '0;
        for (int p = 0; p < PAIRS; p++) begin
            cost_o = cost_o + COST_W'(pair_w[p]);
        end
    end

endmodule

// File: rtl/oebi_select.sv
module oebi_select #(
    parameter int COST_W = 5
) (
    input  logic [oebi_pkg::NUM_MODES-1:0][COST_W-1:0] cost_i,
    output oebi_pkg::inv_mode_e                         pick_o
);
    import oebi_pkg::*;

    logic [COST_W-1:0] best;

    always_comb begin
        best   = cost_i[0];
        pick_o = MODE_PLAIN;
        for (int k = 1; k < NUM_MODES; k++) begin
            if (cost_i[k] < best) begin
                best   = cost_i[k];
                pick_o = inv_mode_e'(k[1:0]);
            end
        end
    end

    always_comb begin
        for (int k = 0; k < NUM_MODES; k++) begin
            if (k < int'(pick_o)) begin
                // R5
                lower_mode_dearer_chk: assert (cost_i[k] > cost_i[pick_o]);
            end else begin
                // R4
                pick_is_min_chk: assert (cost_i[k] >= cost_i[pick_o]);
            end
        end
    end

endmodule

// File: rtl/oebi_decoder.sv
module oebi_decoder #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W+1:0] bus_i,
    output logic [DATA_W-1:0] data_o
);
    localparam int BUS_W = DATA_W + 2;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if ((i % 2) == 0) begin : g_even
            assign data_o[i] = bus_i[i+1] ^ bus_i[BUS_W-1];
        end else begin : g_odd
            assign data_o[i] = bus_i[i+1] ^ bus_i[0];
        end
    end

endmodule

// File: rtl/oebi_encoder.sv
module oebi_encoder #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic [DATA_W+1:0] bus_out,
    output logic              bus_valid,
    output logic [DATA_W-1:0] rt_data
);
    import oebi_pkg::*;

    localparam int BUS_W    = DATA_W + 2;
    localparam int MAX_COST = 2 * (BUS_W - 1);
    localparam int COST_W   = $clog2(MAX_COST + 1);

    logic [NUM_MODES-1:0][BUS_W-1:0]  cand;
    logic [NUM_MODES-1:0][COST_W-1:0] cost;
    inv_mode_e                        pick;
    logic [BUS_W-1:0]                 bus_q;
    enc_state_e                       state, state_nx;

    oebi_candidates #(.DATA_W(DATA_W)) u_cand (
        .data_i (in_data),
        .cand_o (cand)
    );

    for (genvar m = 0; m < NUM_MODES; m++) begin : g_cost
        oebi_pair_cost #(.BUS_W(BUS_W), .COST_W(COST_W)) u_cost (
            .prev_i (bus_q),
            .next_i (cand[m]),
            .cost_o (cost[m])
        );
    end

    oebi_select #(.COST_W(COST_W)) u_sel (
        .cost_i (cost),
        .pick_o (pick)
    );

    // next-state: go_send / go_idle
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: state_nx = in_valid ? ST_SEND : ST_IDLE;
            ST_SEND: state_nx = in_valid ? ST_SEND : ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // outputs: bus register, doubling as the reference for the next word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_q <= '0;
        end else if (in_valid) begin
            bus_q <= cand[pick];
        end
    end

    assign bus_out   = bus_q;
    assign bus_valid = (state == ST_SEND);

    oebi_decoder #(.DATA_W(DATA_W)) u_dec (
        .bus_i  (bus_q),
        .data_o (rt_data)
    );

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(bus_out));

    // R6
    valid_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> bus_valid);

    // R6
    no_valid_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !bus_valid);

    // R8
    round_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (rt_data == $past(in_data)));

endmodule

// File: tb/sim_oebi_encoder.sv
module sim_oebi_encoder;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int BW = DW + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic [BW-1:0] bus_out;
    logic          bus_valid;
    logic [DW-1:0] rt_data;

    int checks = 0;
    int errors = 0;
    logic [BW-1:0] ref_prev = '0;
    logic [15:0]   lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    oebi_encoder #(.DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .bus_out(bus_out), .bus_valid(bus_valid), .rt_data(rt_data)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R2 layout model
    function automatic logic [BW-1:0] make_word(logic [DW-1:0] d, int m);
        logic [BW-1:0] w;
        w[0]    = m[1];
        w[BW-1] = m[0];
        for (int i = 0; i < DW; i++) begin
            w[i+1] = d[i] ^ (((i % 2) == 0) ? m[0] : m[1]);
        end
        return w;
    endfunction

    // R3 cost model: |da - db| per adjacent pair
    function automatic int coupling(logic [BW-1:0] p, logic [BW-1:0] n);
        int s = 0;
        for (int i = 0; i < BW-1; i++) begin
            int da = int'(n[i]) - int'(p[i]);
            int db = int'(n[i+1]) - int'(p[i+1]);
            int df = da - db;
            s += (df < 0) ? -df : df;
        end
        return s;
    endfunction

    // R4/R5 selection model
    function automatic logic [BW-1:0] expect_word(logic [BW-1:0] p, logic [DW-1:0] d);
        int best = 1 << 30;
        logic [BW-1:0] w = '0;
        for (int m = 0; m < 4; m++) begin
            int c = coupling(p, make_word(d, m));
            if (c < best) begin
                best = c;
                w = make_word(d, m);
            end
        end
        return w;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        // R1 during reset
        check("R1 bus_out in reset", 32'(bus_out), 32'h0);
        check("R1 bus_valid in reset", 32'(bus_valid), 32'h0);
        rst_n = 1'b1;
        ref_prev = '0;
        @(negedge clk);
    endtask

    // drive one word at a negedge; check at the following negedge
    task automatic send(logic [DW-1:0] d, string tag, logic [BW-1:0] exp_bus);
        in_valid = 1'b1;
        in_data  = d;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " bus_out"}, 32'(bus_out), 32'(exp_bus));
        check("R6 bus_valid after accept", 32'(bus_valid), 32'h1);
        check("R8 rt_data", 32'(rt_data), 32'(d));
        ref_prev = exp_bus;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 bus_out after reset", 32'(bus_out), 32'h0);
        check("R1 bus_valid after reset", 32'(bus_valid), 32'h0);
    endtask

    task automatic t_layout();
        do_reset();
        // all ones from zero: plain and all-flipped cost 2 each, plain wins
        send(8'hFF, "R2 plain layout", 10'h1FE);
        check("R2 model agrees", 32'(expect_word(10'h000, 8'hFF)), 32'h1FE);
    endtask

    task automatic t_tie();
        do_reset();
        // zero word: plain and all-flipped both cost 0 -> mode 00
        send(8'h00, "R5 tie 00 vs 11", 10'h000);
        // 0xAA: even-flip and odd-flip both cost 1 -> mode 01, MSB flag set
        send(8'hAA, "R5 tie 01 vs 10", 10'h3FE);
        check("R2 even flag at MSB", 32'(bus_out[BW-1]), 32'h1);
        check("R2 odd flag at LSB", 32'(bus_out[0]), 32'h0);
    endtask

    task automatic t_idle();
        logic [BW-1:0] held;
        do_reset();
        send(8'h5A, "R4 before idle", expect_word(ref_prev, 8'h5A));
        held = bus_out;
        for (int k = 0; k < 4; k++) begin
            in_data = 8'(k * 37 + 3);
            @(negedge clk);
            check("R7 bus held on idle", 32'(bus_out), 32'(held));
            check("R7 bus_valid low on idle", 32'(bus_valid), 32'h0);
        end
        send(8'hC3, "R7 scored against held", expect_word(held, 8'hC3));
    endtask

    task automatic t_back_to_back();
        do_reset();
        for (int k = 0; k < 6; k++) begin
            logic [DW-1:0] d = 8'(8'h96 ^ (k * 29));
            logic [BW-1:0] e = expect_word(ref_prev, d);
            in_valid = 1'b1;
            in_data  = d;
            @(negedge clk);
            check("R6 back-to-back bus_out", 32'(bus_out), 32'(e));
            check("R6 back-to-back valid", 32'(bus_valid), 32'h1);
            ref_prev = e;
        end
        in_valid = 1'b0;
        @(negedge clk);
        check("R6 valid drops", 32'(bus_valid), 32'h0);
    endtask

    task automatic t_sweep();
        do_reset();
        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[0] && lfsr[5]) begin
                @(negedge clk);
                check("R7 sweep idle hold", 32'(bus_out), 32'(ref_prev));
            end else begin
                send(lfsr[15:8], "R3 R4 sweep", expect_word(ref_prev, lfsr[15:8]));
            end
        end
    endtask

    initial begin
        t_reset();
        t_layout();
        t_tie();
        t_idle();
        t_back_to_back();
        t_sweep();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule